// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block translates a 32-bit virtual address into a physical address using a small set-associative cache of page mappings. Pages are 4 KiB. The low bits of the virtual page number pick one set. Every way of that set is compared in parallel, and a matching entry supplies a page frame number and read, write and execute permissions. The way count, entry count and address-space ID width are parameters.

A mapping matches only when three conditions hold: its valid flag is set, its stored page number equals the lookup page number, and it is either marked global or carries the same address-space ID as the lookup. The lookup path is combinational. It also reports whether the requested kind of access (read, write or fetch) is allowed.

A maintenance port writes or reads one entry at a time, chosen by way and set. Software or a page walker uses this port to fill and inspect the buffer.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every tag and data word reads as zero, and no lookup hits until an entry has been written with its valid flag set.
- R2: A lookup hits only on an entry of the selected set whose valid flag (tag bit 10) is 1 and whose stored page number (tag bits 31:12) equals virtual address bits 31:12. The entry's ID (tag bits ID_W-1:0) must also equal the lookup ID, unless R3 applies.
- R3: An entry whose global flag (tag bit 11) is 1 matches for any lookup ID.
- R4: The set is selected by the low log2(NUM_ENTRIES/NUM_WAYS) bits of the page number. An entry stored in a different set never hits, even when its tag matches.
- R5: On a hit, the physical address is the frame number (data bits 19:0) shifted left by 12, with virtual address bits 11:0 appended. On a miss, the physical address is zero.
- R6: On a hit, the permission output is {execute, write, read}, taken from data bits 20, 21 and 22 of the matching entry. On a miss it is zero.
- R7: The access-allowed output is 1 only on a hit where the permission for the access type is set. The access type encodes read as 0, write as 1 and fetch as 2. Code 3 is never allowed.
- R8: If several ways hit, the lowest-numbered way supplies the result.
- R9: A maintenance write is visible to lookups and read-back from the next clock edge. Tag bits 9:ID_W read back as zero, and data bits 31:24 read back as zero.
- R10: A maintenance write changes only the addressed way and set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_vaddr_i | input | 32 | Lookup virtual address |
| lk_acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| lk_asid_i | input | ID_W | Current address-space ID |
| lk_hit_o | output | 1 | A matching entry was found |
| lk_paddr_o | output | 32 | Translated physical address |
| lk_perm_o | output | 3 | {execute, write, read} of the hit entry |
| lk_ok_o | output | 1 | Hit and the requested access is permitted |
| mt_we_i | input | 1 | Maintenance write strobe |
| mt_way_i | input | WAY_W | Maintenance way select |
| mt_set_i | input | SET_W | Maintenance set select |
| mt_tag_i | input | 32 | Tag word to write |
| mt_data_i | input | 32 | Data word to write |
| mt_tag_o | output | 32 | Tag word at the selected way and set |
| mt_data_o | output | 32 | Data word at the selected way and set |

## Verification
The assertions assume the maintenance way and set are valid indices. They also assume the read-back select is held steady whenever a write-free cycle is used to check that stored state is unchanged.

The stimulus issues a write in one cycle and lookups only in later cycles, so no result depends on a lookup that overlaps a write to the same entry. It deliberately places several tags in the wrong set, and several copies of the same page in different ways. This exercises the selection and priority rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PG_SH  = 12;
  localparam int unsigned VPN_W  = VA_W - PG_SH;
  localparam int unsigned PFN_W  = 20;
  localparam int unsigned T_GLB  = 11;
  localparam int unsigned T_VLD  = 10;
  localparam int unsigned D_X    = 20;
  localparam int unsigned D_W    = 21;
  localparam int unsigned D_R    = 22;
  localparam int unsigned D_KEEP = 24;
  // looked-up payload: {r, w, x, pfn}
  localparam int unsigned HIT_W  = PFN_W + 3;

  typedef enum logic [1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_EX   = 2'd2,
    ACC_NONE = 2'd3
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic logic [VA_W-1:0] tag_mask(input int unsigned id_w);
    logic [VA_W-1:0] m;
    m = '0;
    for (int i = 0; i < VA_W; i++)
      if (i >= T_VLD || i < id_w) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned ID_W  = 8,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SET_W-1:0]              wset_i,
  input  logic [tlb_pkg::VA_W-1:0]      wtag_i,
  input  logic [tlb_pkg::VA_W-1:0]      wdata_i,
  input  logic [SET_W-1:0]              lk_set_i,
  input  logic [tlb_pkg::VPN_W-1:0]     lk_vpn_i,
  input  logic [ID_W-1:0]               lk_asid_i,
  input  logic [SET_W-1:0]              rd_set_i,
  output logic                          hit_o,
  output logic [tlb_pkg::HIT_W-1:0]     hit_data_o,
  output logic [tlb_pkg::VA_W-1:0]      rd_tag_o,
  output logic [tlb_pkg::VA_W-1:0]      rd_data_o
);
  import tlb_pkg::*;

  localparam logic [VA_W-1:0] TMASK = tag_mask(ID_W);
  localparam logic [VA_W-1:0] DMASK = (VA_W)'((64'd1 << D_KEEP) - 1);

  logic [VA_W-1:0] tag_q  [SETS];
  logic [VA_W-1:0] data_q [SETS];
  logic [VA_W-1:0] tag_m, data_m;
  logic [VA_W-1:0] lk_tag, lk_data;

  assign tag_m  = wtag_i & TMASK;
  assign data_m = wdata_i & DMASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        data_q[s] <= '0;
      end
    end else if (we_i) begin
      tag_q[wset_i]  <= tag_m;
      data_q[wset_i] <= data_m;
    end
  end

  assign lk_tag  = tag_q[lk_set_i];
  assign lk_data = data_q[lk_set_i];

  always_comb begin
    hit_o = lk_tag[T_VLD]
          && (lk_tag[VA_W-1:PG_SH] == lk_vpn_i)
          && (lk_tag[T_GLB] || (lk_tag[ID_W-1:0] == lk_asid_i));
    hit_data_o = lk_data[HIT_W-1:0];
  end

  assign rd_tag_o  = tag_q[rd_set_i];
  assign rd_data_o = data_q[rd_set_i];

  p_wr_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (tag_q[$past(wset_i)] == $past(tag_m)) && (data_q[$past(wset_i)] == $past(data_m)));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && rst_ni) |=> (rd_set_i != $past(rd_set_i)) || $stable(rd_tag_o));
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [DW-1:0] data_i [N],
  output logic          any_o,
  output logic [DW-1:0] data_o
);
  logic [N-1:0] gnt;
  logic [N-1:0] seen;

  // ascending scan: lowest index wins
  always_comb begin
    gnt = '0;
    seen = '0;
    for (int i = 0; i < N; i++) begin
      if (i == 0) gnt[i] = req_i[i];
      else        gnt[i] = req_i[i] && !seen[i-1];
      seen[i] = (i == 0) ? req_i[i] : (seen[i-1] || req_i[i]);
    end
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) data_o = data_i[i];
  end

  assign any_o = seen[N-1];

  p_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  p_lowest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt != '0) |-> ((req_i & (gnt - 1'b1)) == '0));
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int unsigned NUM_WAYS    = 4,
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned ID_W        = 8,
  localparam int unsigned SETS  = NUM_ENTRIES / NUM_WAYS,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      lk_vaddr_i,
  input  logic [1:0]       lk_acc_i,
  input  logic [ID_W-1:0]  lk_asid_i,
  output logic             lk_hit_o,
  output logic [31:0]      lk_paddr_o,
  output logic [2:0]       lk_perm_o,
  output logic             lk_ok_o,
  input  logic             mt_we_i,
  input  logic [WAY_W-1:0] mt_way_i,
  input  logic [SET_W-1:0] mt_set_i,
  input  logic [31:0]      mt_tag_i,
  input  logic [31:0]      mt_data_i,
  output logic [31:0]      mt_tag_o,
  output logic [31:0]      mt_data_o
);
  import tlb_pkg::*;

  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_set;
  logic [NUM_WAYS-1:0] way_hit;
  logic [HIT_W-1:0]    way_dat [NUM_WAYS];
  logic [VA_W-1:0]     way_rtag [NUM_WAYS];
  logic [VA_W-1:0]     way_rdat [NUM_WAYS];
  logic                any_hit;
  logic [HIT_W-1:0]    sel_dat;
  perm_t               perm;
  acc_e                acc;

  assign lk_vpn = lk_vaddr_i[VA_W-1:PG_SH];
  assign lk_set = lk_vpn[SET_W-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way #(.SETS(SETS), .ID_W(ID_W)) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (mt_we_i && (mt_way_i == WAY_W'(w))),
      .wset_i     (mt_set_i),
      .wtag_i     (mt_tag_i),
      .wdata_i    (mt_data_i),
      .lk_set_i   (lk_set),
      .lk_vpn_i   (lk_vpn),
      .lk_asid_i  (lk_asid_i),
      .rd_set_i   (mt_set_i),
      .hit_o      (way_hit[w]),
      .hit_data_o (way_dat[w]),
      .rd_tag_o   (way_rtag[w]),
      .rd_data_o  (way_rdat[w])
    );
  end

  tlb_pick #(.N(NUM_WAYS), .DW(HIT_W)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (way_hit),
    .data_i (way_dat),
    .any_o  (any_hit),
    .data_o (sel_dat)
  );

  always_comb begin
    acc    = acc_e'(lk_acc_i);
    perm.r = sel_dat[D_R];
    perm.w = sel_dat[D_W];
    perm.x = sel_dat[D_X];
    lk_hit_o   = any_hit;
    lk_paddr_o = any_hit ? {sel_dat[PFN_W-1:0], lk_vaddr_i[PG_SH-1:0]} : '0;
    lk_perm_o  = any_hit ? perm : '0;
    unique case (acc)
      ACC_RD:  lk_ok_o = any_hit && perm.r;
      ACC_WR:  lk_ok_o = any_hit && perm.w;
      ACC_EX:  lk_ok_o = any_hit && perm.x;
      default: lk_ok_o = 1'b0;
    endcase
  end

  assign mt_tag_o  = way_rtag[mt_way_i];
  assign mt_data_o = way_rdat[mt_way_i];

  p_miss_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0) && (lk_perm_o == '0));

  p_ok_needs_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_ok_o |-> lk_hit_o && (lk_acc_i != 2'd3));

  p_ok_perm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_ok_o |-> lk_perm_o[lk_acc_i]);
endmodule

// File: tb/tb_tlb_assoc.sv
module tb_tlb_assoc;
  localparam int WAYS = 4;
  localparam int ENT  = 64;
  localparam int IDW  = 8;
  localparam int SETS = ENT / WAYS;
  localparam int SW   = $clog2(SETS);
  localparam int WW   = $clog2(WAYS);
  localparam logic [31:0] TMASK = 32'hFFFF_FC00 | ((32'd1 << IDW) - 1);
  localparam logic [31:0] DMASK = 32'h00FF_FFFF;

  typedef struct {
    string       req;
    logic        hit;
    logic [31:0] pa;
    logic [2:0]  perm;
    logic        ok;
    logic [31:0] rt;
    logic [31:0] rd;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [31:0] lk_va = 0;
  logic [1:0] lk_acc = 0;
  logic [IDW-1:0] lk_id = 0;
  logic hit, ok;
  logic [31:0] pa, rtag, rdat;
  logic [2:0] perm;
  logic we = 0;
  logic [WW-1:0] way = 0;
  logic [SW-1:0] set = 0;
  logic [31:0] wtag = 0, wdat = 0;

  int tests = 0, fails = 0;
  exp_t q[$];
  logic [31:0] m_tag [WAYS][SETS];
  logic [31:0] m_dat [WAYS][SETS];
  bit done = 0;

  always #10 clk = ~clk;

  tlb_assoc #(.NUM_WAYS(WAYS), .NUM_ENTRIES(ENT), .ID_W(IDW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_vaddr_i(lk_va), .lk_acc_i(lk_acc), .lk_asid_i(lk_id),
    .lk_hit_o(hit), .lk_paddr_o(pa), .lk_perm_o(perm), .lk_ok_o(ok),
    .mt_we_i(we), .mt_way_i(way), .mt_set_i(set),
    .mt_tag_i(wtag), .mt_data_i(wdat),
    .mt_tag_o(rtag), .mt_data_o(rdat)
  );

  task automatic wr(input int w, input int s, input logic [31:0] t, input logic [31:0] d);
    @(negedge clk);
    we = 1; way = WW'(w); set = SW'(s); wtag = t; wdat = d;
    @(negedge clk);
    we = 0;
    m_tag[w][s] = t & TMASK;
    m_dat[w][s] = d & DMASK;
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic [1:0] acc,
                      input logic [IDW-1:0] id, input int rw, input int rs);
    exp_t e;
    logic [31:0] vpn;
    int s;
    vpn = va >> 12;
    s = int'(vpn) % SETS;
    e.req = req; e.hit = 0; e.pa = 0; e.perm = 0; e.ok = 0;
    for (int w = 0; w < WAYS; w++) begin
      logic [31:0] t, d;
      t = m_tag[w][s]; d = m_dat[w][s];
      if (!e.hit && t[10] && (t >> 12) == vpn && (t[11] || t[IDW-1:0] == id)) begin
        e.hit = 1;
        e.pa = {d[19:0], va[11:0]};
        e.perm = {d[20], d[21], d[22]};
        e.ok = (acc == 0) ? d[22] : (acc == 1) ? d[21] : (acc == 2) ? d[20] : 1'b0;
      end
    end
    e.rt = m_tag[rw][rs];
    e.rd = m_dat[rw][rs];
    @(negedge clk);
    lk_va = va; lk_acc = acc; lk_id = id; way = WW'(rw); set = SW'(rs);
    q.push_back(e);
  endtask

  // monitor: compare one item per cycle after the edge
  initial forever begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (hit !== e.hit || pa !== e.pa || perm !== e.perm || ok !== e.ok ||
          rtag !== e.rt || rdat !== e.rd) begin
        fails++;
        $display("FAIL %s: got hit=%b pa=%h perm=%b ok=%b rt=%h rd=%h exp hit=%b pa=%h perm=%b ok=%b rt=%h rd=%h",
                 e.req, hit, pa, perm, ok, rtag, rdat, e.hit, e.pa, e.perm, e.ok, e.rt, e.rd);
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < WAYS; w++)
      for (int s = 0; s < SETS; s++) begin
        m_tag[w][s] = 0; m_dat[w][s] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: cleared after reset
    look("R1", 32'h0000_0123, 2'd0, 8'd0, 0, 0);
    look("R1", 32'h0000_3000, 2'd0, 8'd5, 3, 15);
    // entry way0 set3: vpn 3, id 5, pfn ABCDE, r+w
    wr(0, 3, 32'h0000_3405, 32'h0060_0000 | 32'hABCDE);
    look("R2", 32'h0000_3123, 2'd0, 8'd5, 0, 3);
    look("R5", 32'h0000_3FFF, 2'd1, 8'd5, 0, 3);
    look("R7", 32'h0000_3000, 2'd2, 8'd5, 0, 3);
    look("R7", 32'h0000_3000, 2'd3, 8'd5, 0, 3);
    look("R2", 32'h0000_3123, 2'd0, 8'd6, 0, 3);
    look("R2", 32'h0001_3123, 2'd0, 8'd5, 0, 3);
    // R3: global, way1 set4, execute only
    wr(1, 4, 32'h1000_4C01, 32'h0010_0000 | 32'h12345);
    look("R3", 32'h1000_4ABC, 2'd2, 8'd9, 1, 4);
    look("R6", 32'h1000_4ABC, 2'd0, 8'd1, 1, 4);
    // R2: valid clear never hits
    wr(2, 5, 32'h0000_5005, 32'h0070_0001);
    look("R2", 32'h0000_5000, 2'd0, 8'd5, 2, 5);
    // R4: right set vs wrong set
    wr(2, 3, 32'h0001_3405, 32'h0040_0777);
    look("R4", 32'h0001_3010, 2'd0, 8'd5, 2, 3);
    wr(3, 2, 32'h0000_7405, 32'h0040_0888);
    look("R4", 32'h0000_7010, 2'd0, 8'd5, 3, 2);
    // R8: duplicate in way3 set3
    wr(3, 3, 32'h0000_3405, 32'h0020_0999);
    look("R8", 32'h0000_3444, 2'd1, 8'd5, 3, 3);
    wr(0, 3, 32'h0000_3005, 32'h0060_ABCD);
    look("R8", 32'h0000_3444, 2'd1, 8'd5, 0, 3);
    // R9: masked read-back
    wr(1, 9, 32'h0000_9FFF, 32'hFFFF_FFFF);
    look("R9", 32'h0000_9001, 2'd0, 8'hFF, 1, 9);
    // R10: neighbours unchanged
    look("R10", 32'h0000_0000, 2'd0, 8'd0, 1, 4);
    look("R10", 32'h0000_0000, 2'd0, 8'd0, 2, 3);
    look("R10", 32'h0000_0000, 2'd0, 8'd0, 0, 9);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule